// File: doc/BRIEF.md
# Daisy-Chain Poll Capture Unit

This block is the poll responder of a single device adapter on a priority bus where devices are chained one after another. The adapter raises either a cycle-steal request or an interrupt request. An interrupt request carries a 4-bit priority level, which a prepare command loaded earlier. The unit presents the pending request to the channel as request lines. It then watches the channel's poll identifier and poll strobe. For each poll it either captures the poll by driving a return tag, or hands it on to the next device in the chain.

The decision is made ahead of the poll strobe. When the poll identifier becomes active, the unit takes one sample of its request state. It freezes that sample for the rest of the poll sequence and waits a fixed deskew interval before it honours the strobe. The channel inputs pass through multi-stage synchronizers, and every output is a register. After a capture, the request lines stay blocked until the adapter reports that the service sequence has completed.

A device-reset command clears only the interrupt side. A captured or pending cycle steal survives it.

Top module: `poll_capture_unit`

## Requirements
- R1: While `rst_ni` is low, every output is 0.
- R2: A one-cycle pulse on `cs_req_i` raises `cs_req_o` two clock edges later. A pulse on `irq_req_i` together with `prep_load_i` and level L raises only bit L of `req_in_o` (one-hot, bit index equals level). While a cycle-steal request is pending, `req_in_o` stays 0 and a simultaneous `irq_req_i` is ignored, so cycle steal wins.
- R3: The poll identifier field is decoded as follows. `poll_id_i[5:4]` = 2'b10 is a cycle-steal poll and 2'b01 is an interrupt poll; any other value is no poll. `poll_id_i[3:0]` is the polled level.
- R4: An interrupt poll is captured only when the polled level equals the stored level. On a mismatch the poll is propagated.
- R5: Request state is sampled once, when the decoded poll identifier first becomes active. A request that arrives later has no effect on that poll sequence, which then propagates.
- R6: The strobe is honoured only after DESKEW (2) clocks past the sample. When `poll_id_i` and `poll_i` change together, the tag output rises on the sixth rising edge and never earlier. With nothing sampled, the poll propagates.
- R7: During an honoured poll, exactly one of `poll_prop_o` and `poll_ret_o` is high. A return sets `capture_o` on the same edge. Both tags drop after `poll_i` falls.
- R8: While `capture_o` is high, `cs_req_o` and `req_in_o` are 0 and later polls propagate. A `svc_done_i` pulse clears `capture_o`, `capt_cs_o` and the captured request.
- R9: `dev_reset_i` clears the interrupt request, the stored level and an interrupt capture. It leaves a pending cycle-steal request and a cycle-steal capture (`capt_cs_o`) untouched.
- R10: Asserting `rst_ni` clears all state and outputs at once, regardless of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Adapter clock |
| rst_ni | input | 1 | Channel reset, active low, asynchronous assert |
| cs_req_i | input | 1 | Cycle-steal request pulse |
| irq_req_i | input | 1 | Interrupt request pulse |
| prep_load_i | input | 1 | Prepare command: load interrupt level |
| prep_level_i | input | 4 | Interrupt level to load |
| dev_reset_i | input | 1 | Device-reset command pulse |
| svc_done_i | input | 1 | Service sequence complete pulse |
| poll_id_i | input | 6 | Poll identifier from channel (asynchronous) |
| poll_i | input | 1 | Poll strobe from channel (asynchronous) |
| cs_req_o | output | 1 | Cycle-steal request line to channel |
| req_in_o | output | 16 | Interrupt request-in lines, one per level |
| poll_prop_o | output | 1 | Poll handed to next device |
| poll_ret_o | output | 1 | Poll-return tag (capture) |
| capture_o | output | 1 | Poll-capture latch |
| capt_cs_o | output | 1 | Capture belongs to a cycle steal |

## Verification
Several properties are checked on every cycle:
- the two tags are mutually exclusive;
- the request lines are one-hot;
- a held capture blocks the request lines;
- a return coincides with capture;
- a tag never rises before the deskew count completes;
- capture persists until service completion, and a cycle-steal capture survives device reset.

Some behaviours can only be shown by the bench's scenarios. These are the exact level compare, the freezing of the sample against late requests, the exact edge on which a tag appears, and which request the unit captures across random sequences of requests, polls, completions and device resets.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_CS   = 2'd1,
    PK_IRQ  = 2'd2
  } poll_kind_e;

  // Two kind bits of the poll identifier: 10 = cycle steal, 01 = interrupt.
  function automatic poll_kind_e decode_kind(input logic [1:0] sel);
    case (sel)
      2'b10:   return PK_CS;
      2'b01:   return PK_IRQ;
      default: return PK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pcu_sync.sv
module pcu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pcu_req_stage.sv
module pcu_req_stage #(
  parameter int LVL_W = 4,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_req_i,
  input  logic               irq_req_i,
  input  logic               prep_load_i,
  input  logic [LVL_W-1:0]   prep_level_i,
  input  logic               dev_reset_i,
  input  logic               svc_done_i,
  input  logic               cap_i,
  input  logic               cap_cs_i,
  output logic               cs_lat_o,
  output logic               irq_lat_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               cs_req_o,
  output logic [NUM_LVL-1:0] req_in_o
);

  logic               cs_q, cs_d;
  logic               irq_q, irq_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic               cs_out_q, cs_out_d;
  logic [NUM_LVL-1:0] req_q, req_d;
  logic               irq_show;

  always_comb begin
    cs_d = cs_q;
    if (svc_done_i && cap_i && cap_cs_i) cs_d = 1'b0;
    if (cs_req_i)                        cs_d = 1'b1;

    irq_d = irq_q;
    if (svc_done_i && cap_i && !cap_cs_i) irq_d = 1'b0;
    if (irq_req_i && !cs_req_i)           irq_d = 1'b1;
    if (dev_reset_i)                      irq_d = 1'b0;

    lvl_d = lvl_q;
    if (prep_load_i) lvl_d = prep_level_i;
    if (dev_reset_i) lvl_d = '0;

    cs_out_d = cs_q && !cap_i;
    irq_show = irq_q && !cs_q && !cap_i;
    for (int i = 0; i < NUM_LVL; i++) begin
      req_d[i] = irq_show && (lvl_q == LVL_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b0;
      irq_q    <= 1'b0;
      lvl_q    <= '0;
      cs_out_q <= 1'b0;
      req_q    <= '0;
    end else begin
      cs_q     <= cs_d;
      irq_q    <= irq_d;
      lvl_q    <= lvl_d;
      cs_out_q <= cs_out_d;
      req_q    <= req_d;
    end
  end

  assign cs_lat_o  = cs_q;
  assign irq_lat_o = irq_q;
  assign level_o   = lvl_q;
  assign cs_req_o  = cs_out_q;
  assign req_in_o  = req_q;

endmodule

// File: rtl/pcu_poll_ctrl.sv
module pcu_poll_ctrl
  import poll_pkg::*;
#(
  parameter int LVL_W  = 4,
  parameter int DESKEW = 2,
  localparam int ID_W  = LVL_W + 2,
  localparam int CNT_W = $clog2(DESKEW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  poll_id_s_i,
  input  logic             poll_s_i,
  input  logic             cs_lat_i,
  input  logic             irq_lat_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             dev_reset_i,
  input  logic             svc_done_i,
  output logic             poll_prop_o,
  output logic             poll_ret_o,
  output logic             cap_o,
  output logic             cap_cs_o,
  output logic             deskew_ok_o
);

  poll_kind_e       kind;
  logic             id_active, deskew_ok, active, fire;
  logic [LVL_W-1:0] id_lvl;

  logic             armed_q, armed_d;
  logic             smp_cs_q, smp_cs_d;
  logic             smp_irq_q, smp_irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_q, dec_d;
  logic             used_q, used_d;
  logic             prop_q, prop_d;
  logic             ret_q, ret_d;
  logic             cap_q, cap_d;
  logic             capcs_q, capcs_d;

  always_comb begin
    kind      = decode_kind(poll_id_s_i[ID_W-1:LVL_W]);
    id_active = (kind != PK_NONE);
    id_lvl    = poll_id_s_i[LVL_W-1:0];
    deskew_ok = (cnt_q == CNT_W'(DESKEW));
    active    = prop_q || ret_q;
    fire      = poll_s_i && id_active && deskew_ok && !active && !used_q;

    armed_d   = armed_q;
    smp_cs_d  = smp_cs_q;
    smp_irq_d = smp_irq_q;
    cnt_d     = cnt_q;
    used_d    = used_q;
    prop_d    = prop_q;
    ret_d     = ret_q;
    cap_d     = cap_q;
    capcs_d   = capcs_q;

    // Sample once per identifier activation, then count out the deskew window.
    if (!id_active) begin
      armed_d   = 1'b0;
      smp_cs_d  = 1'b0;
      smp_irq_d = 1'b0;
      cnt_d     = '0;
      used_d    = 1'b0;
    end else begin
      if (!armed_q) begin
        armed_d   = 1'b1;
        smp_cs_d  = (kind == PK_CS) && cs_lat_i && !cap_q;
        smp_irq_d = (kind == PK_IRQ) && irq_lat_i && !cs_lat_i && !cap_q &&
                    (level_i == id_lvl);
      end
      if (armed_q && !deskew_ok) cnt_d = cnt_q + CNT_W'(1);
    end
    if (dev_reset_i) smp_irq_d = 1'b0;

    // Decision follows the samples until a poll is being answered.
    dec_d = active ? dec_q : (smp_cs_q || smp_irq_q);

    if (svc_done_i && cap_q) begin
      cap_d   = 1'b0;
      capcs_d = 1'b0;
    end
    if (dev_reset_i && cap_q && !capcs_q) cap_d = 1'b0;

    if (fire) begin
      prop_d = !dec_q;
      ret_d  = dec_q;
      used_d = 1'b1;
      if (dec_q) begin
        cap_d   = 1'b1;
        capcs_d = smp_cs_q;
      end
    end
    if (!poll_s_i) begin
      prop_d = 1'b0;
      ret_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      smp_cs_q  <= 1'b0;
      smp_irq_q <= 1'b0;
      cnt_q     <= '0;
      dec_q     <= 1'b0;
      used_q    <= 1'b0;
      prop_q    <= 1'b0;
      ret_q     <= 1'b0;
      cap_q     <= 1'b0;
      capcs_q   <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      smp_cs_q  <= smp_cs_d;
      smp_irq_q <= smp_irq_d;
      cnt_q     <= cnt_d;
      dec_q     <= dec_d;
      used_q    <= used_d;
      prop_q    <= prop_d;
      ret_q     <= ret_d;
      cap_q     <= cap_d;
      capcs_q   <= capcs_d;
    end
  end

  assign poll_prop_o = prop_q;
  assign poll_ret_o  = ret_q;
  assign cap_o       = cap_q;
  assign cap_cs_o    = capcs_q;
  assign deskew_ok_o = deskew_ok;

endmodule

// File: rtl/poll_capture_unit.sv
module poll_capture_unit #(
  parameter int LVL_W       = 4,
  parameter int DESKEW      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W       = LVL_W + 2,
  localparam int NUM_LVL    = 1 << LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_req_i,
  input  logic               irq_req_i,
  input  logic               prep_load_i,
  input  logic [LVL_W-1:0]   prep_level_i,
  input  logic               dev_reset_i,
  input  logic               svc_done_i,
  input  logic [ID_W-1:0]    poll_id_i,
  input  logic               poll_i,
  output logic               cs_req_o,
  output logic [NUM_LVL-1:0] req_in_o,
  output logic               poll_prop_o,
  output logic               poll_ret_o,
  output logic               capture_o,
  output logic               capt_cs_o
);

  logic            rst_sn;
  logic [ID_W:0]   chan_s;
  logic            cs_lat, irq_lat, deskew_ok;
  logic [LVL_W-1:0] level;

  pcu_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_sn)
  );

  pcu_sync #(.W(ID_W + 1), .STAGES(SYNC_STAGES)) u_chan_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .d_i    ({poll_i, poll_id_i}),
    .q_o    (chan_s)
  );

  pcu_req_stage #(.LVL_W(LVL_W)) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_sn),
    .cs_req_i     (cs_req_i),
    .irq_req_i    (irq_req_i),
    .prep_load_i  (prep_load_i),
    .prep_level_i (prep_level_i),
    .dev_reset_i  (dev_reset_i),
    .svc_done_i   (svc_done_i),
    .cap_i        (capture_o),
    .cap_cs_i     (capt_cs_o),
    .cs_lat_o     (cs_lat),
    .irq_lat_o    (irq_lat),
    .level_o      (level),
    .cs_req_o     (cs_req_o),
    .req_in_o     (req_in_o)
  );

  pcu_poll_ctrl #(.LVL_W(LVL_W), .DESKEW(DESKEW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sn),
    .poll_id_s_i (chan_s[ID_W-1:0]),
    .poll_s_i    (chan_s[ID_W]),
    .cs_lat_i    (cs_lat),
    .irq_lat_i   (irq_lat),
    .level_i     (level),
    .dev_reset_i (dev_reset_i),
    .svc_done_i  (svc_done_i),
    .poll_prop_o (poll_prop_o),
    .poll_ret_o  (poll_ret_o),
    .cap_o       (capture_o),
    .cap_cs_o    (capt_cs_o),
    .deskew_ok_o (deskew_ok)
  );

endmodule

// File: rtl/poll_capture_unit_chk.sv
module poll_capture_unit_chk #(
  parameter int LVL_W = 4,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input logic               clk_i,
  input logic               rst_sn,
  input logic               cs_req_i,
  input logic               irq_req_i,
  input logic               svc_done_i,
  input logic               dev_reset_i,
  input logic               cs_req_o,
  input logic [NUM_LVL-1:0] req_in_o,
  input logic               poll_prop_o,
  input logic               poll_ret_o,
  input logic               capture_o,
  input logic               capt_cs_o,
  input logic               deskew_ok
);

  // R2
  no_dual_req_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !(cs_req_i && irq_req_i));

  // R2
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    $onehot0(req_in_o));

  // R7
  tag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !(poll_prop_o && poll_ret_o));

  // R7
  ret_sets_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    $rose(poll_ret_o) |-> capture_o);

  // R6
  deskew_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    $rose(poll_prop_o || poll_ret_o) |-> $past(deskew_ok));

  // R8
  req_block_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (capture_o && $past(capture_o)) |-> (!cs_req_o && req_in_o == '0));

  // R8
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (capture_o && !svc_done_i && !dev_reset_i) |=> capture_o);

  // R8
  svc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (capture_o && svc_done_i) |=> !capture_o);

  // R9
  cs_survive_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (capture_o && capt_cs_o && !svc_done_i) |=> (capture_o && capt_cs_o));

endmodule

bind poll_capture_unit poll_capture_unit_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_sn      (rst_sn),
  .cs_req_i    (cs_req_i),
  .irq_req_i   (irq_req_i),
  .svc_done_i  (svc_done_i),
  .dev_reset_i (dev_reset_i),
  .cs_req_o    (cs_req_o),
  .req_in_o    (req_in_o),
  .poll_prop_o (poll_prop_o),
  .poll_ret_o  (poll_ret_o),
  .capture_o   (capture_o),
  .capt_cs_o   (capt_cs_o),
  .deskew_ok   (deskew_ok)
);

// File: tb/poll_capture_unit_tb_top.sv
module poll_capture_unit_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cs_req_i, irq_req_i, prep_load_i, dev_reset_i, svc_done_i, poll_i;
  logic [3:0]  prep_level_i;
  logic [5:0]  poll_id_i;
  logic        cs_req_o, poll_prop_o, poll_ret_o, capture_o, capt_cs_o;
  logic [15:0] req_in_o;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of the requirements
  bit       m_cs, m_irq, m_cap, m_capcs;
  bit [3:0] m_lvl;

  always #10 clk_i = ~clk_i;

  poll_capture_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_req_i(cs_req_i), .irq_req_i(irq_req_i),
    .prep_load_i(prep_load_i), .prep_level_i(prep_level_i), .dev_reset_i(dev_reset_i),
    .svc_done_i(svc_done_i), .poll_id_i(poll_id_i), .poll_i(poll_i),
    .cs_req_o(cs_req_o), .req_in_o(req_in_o), .poll_prop_o(poll_prop_o),
    .poll_ret_o(poll_ret_o), .capture_o(capture_o), .capt_cs_o(capt_cs_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [15:0] exp_req_in();
    return (m_irq && !m_cs && !m_cap) ? (16'h1 << m_lvl) : 16'h0;
  endfunction

  task automatic check_state(input string req);
    cyc(3);
    chk({req, " cs_req_o"}, 32'(cs_req_o), 32'(m_cs && !m_cap));
    chk({req, " req_in_o"}, 32'(req_in_o), 32'(exp_req_in()));
    chk({req, " capture_o"}, 32'(capture_o), 32'(m_cap));
    chk({req, " capt_cs_o"}, 32'(capt_cs_o), 32'(m_capcs));
  endtask

  task automatic req_cs();
    cs_req_i = 1'b1; cyc(1); cs_req_i = 1'b0;
    m_cs = 1'b1;
  endtask

  task automatic req_irq(input logic [3:0] lvl);
    irq_req_i = 1'b1; prep_load_i = 1'b1; prep_level_i = lvl;
    cyc(1);
    irq_req_i = 1'b0; prep_load_i = 1'b0;
    m_irq = 1'b1; m_lvl = lvl;
  endtask

  task automatic svc_done();
    svc_done_i = 1'b1; cyc(1); svc_done_i = 1'b0;
    if (m_cap) begin
      if (m_capcs) m_cs = 1'b0; else m_irq = 1'b0;
      m_cap = 1'b0; m_capcs = 1'b0;
    end
  endtask

  task automatic dev_reset();
    dev_reset_i = 1'b1; cyc(1); dev_reset_i = 1'b0;
    m_irq = 1'b0; m_lvl = 4'd0;
    if (m_cap && !m_capcs) m_cap = 1'b0;
  endtask

  // kind: 1 = cycle-steal poll (10), 0 = interrupt poll (01)
  task automatic do_poll(input bit is_cs, input logic [3:0] lvl, input string req);
    bit ret;
    ret = is_cs ? (m_cs && !m_cap)
                : (m_irq && !m_cs && !m_cap && m_lvl == lvl);
    poll_id_i = {is_cs ? 2'b10 : 2'b01, lvl};
    cyc(1);
    poll_i = 1'b1;
    cyc(8);
    chk({req, " poll_ret_o"}, 32'(poll_ret_o), 32'(ret));
    chk({req, " poll_prop_o"}, 32'(poll_prop_o), 32'(!ret));
    if (ret) begin m_cap = 1'b1; m_capcs = is_cs; end
    chk({req, " capture_o after poll"}, 32'(capture_o), 32'(m_cap));
    poll_i = 1'b0;
    cyc(4);
    chk({req, " tags drop"}, 32'({poll_prop_o, poll_ret_o}), 32'(0));
    poll_id_i = 6'd0;
    cyc(4);
  endtask

  task automatic model_clear();
    m_cs = 0; m_irq = 0; m_cap = 0; m_capcs = 0; m_lvl = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    rst_ni = 1'b0; cs_req_i = 0; irq_req_i = 0; prep_load_i = 0; prep_level_i = 0;
    dev_reset_i = 0; svc_done_i = 0; poll_id_i = 0; poll_i = 0;
    model_clear();
    cyc(3);
    // R1
    chk("R1 reset outputs", 32'({cs_req_o, req_in_o, poll_prop_o, poll_ret_o, capture_o, capt_cs_o}), 32'(0));
    rst_ni = 1'b1;
    cyc(4);

    // R6: nothing sampled propagates
    do_poll(1'b1, 4'd0, "R6 idle poll");

    // R2 R3 R7 R8: cycle-steal path
    req_cs();
    check_state("R2 cs present");
    do_poll(1'b0, 4'd0, "R3 irq poll vs cs request");
    do_poll(1'b1, 4'd0, "R7 cs capture");
    check_state("R8 blocked");
    do_poll(1'b1, 4'd0, "R8 poll after capture");
    svc_done();
    check_state("R8 svc done");

    // R2 R4 R9: interrupt path
    req_irq(4'd5);
    check_state("R2 irq onehot");
    do_poll(1'b0, 4'd3, "R4 level mismatch");
    do_poll(1'b0, 4'd5, "R4 level match");
    dev_reset();
    check_state("R9 irq capture cleared");

    // R9: cycle-steal capture survives device reset
    req_cs();
    do_poll(1'b1, 4'd0, "R9 cs capture");
    dev_reset();
    check_state("R9 cs survives");
    svc_done();
    check_state("R9 cs svc");

    // R6: exact edge of tag with simultaneous id and poll
    req_cs();
    cyc(3);
    poll_id_i = 6'b10_0000; poll_i = 1'b1;
    cyc(5);
    chk("R6 no tag before deskew", 32'({poll_prop_o, poll_ret_o}), 32'(0));
    cyc(1);
    chk("R6 tag after deskew", 32'(poll_ret_o), 32'(1));
    m_cap = 1; m_capcs = 1;
    poll_i = 1'b0; cyc(4); poll_id_i = 6'd0; cyc(4);
    svc_done();
    check_state("R6 cleanup");

    // R5: request after id activation does not count
    poll_id_i = 6'b01_0111;
    cyc(4);
    irq_req_i = 1'b1; prep_load_i = 1'b1; prep_level_i = 4'd7;
    cyc(1);
    irq_req_i = 1'b0; prep_load_i = 1'b0;
    m_irq = 1; m_lvl = 4'd7;
    poll_i = 1'b1;
    cyc(8);
    chk("R5 late request propagates", 32'(poll_prop_o), 32'(1));
    chk("R5 late request no return", 32'(poll_ret_o), 32'(0));
    poll_i = 1'b0; cyc(4); poll_id_i = 6'd0; cyc(4);
    do_poll(1'b0, 4'd7, "R5 next sequence captures");
    svc_done();
    check_state("R5 cleanup");

    // R2: cycle steal wins over pending interrupt
    req_irq(4'd2);
    req_cs();
    check_state("R2 cs wins lines");
    do_poll(1'b0, 4'd2, "R2 irq poll under cs");
    do_poll(1'b1, 4'd0, "R2 cs poll");
    svc_done();
    check_state("R2 irq re-presented");

    // R10: asynchronous reset mid-sequence
    req_cs();
    poll_id_i = 6'b10_0000; poll_i = 1'b1;
    cyc(2);
    #3 rst_ni = 1'b0;
    #1 chk("R10 async clear", 32'({cs_req_o, req_in_o, poll_prop_o, poll_ret_o, capture_o, capt_cs_o}), 32'(0));
    poll_id_i = 0; poll_i = 0;
    model_clear();
    cyc(2);
    rst_ni = 1'b1;
    cyc(4);
    check_state("R10 after reset");

    // random mix
    for (int k = 0; k < 150; k++) begin
      int op;
      logic [3:0] lv;
      op = int'($urandom_range(0, 5));
      lv = ($urandom_range(0, 1) == 0) ? m_lvl : 4'($urandom_range(0, 15));
      case (op)
        0: req_cs();
        1: req_irq(4'($urandom_range(0, 15)));
        2: do_poll(1'b1, 4'd0, "R7 random cs poll");
        3: do_poll(1'b0, lv, "R4 random irq poll");
        4: svc_done();
        default: dev_reset();
      endcase
      check_state("R8 random state");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule